// File: doc/BRIEF.md
# Banked GPIO register file with masked-write aliases

This block is the register file of one bank of general-purpose pins. The bank has 32 pins, split into four ports of eight. Each port has three writable registers: a function-select register (1 = pin driven by this block), a drive-enable register and a drive-value register. It also has one read-only register, the synchronised pad level. Software reaches the registers over a simple 32-bit read/write bus. The pads see the drive value and a drive enable that is gated by function select.

The registers appear in two address windows. The plain window sits at `BANK_IDX * BANK_STRIDE`. A write there replaces the whole byte of the addressed register. The alias window sits `ALIAS_OFS` above the plain window. A write there changes only the pins whose mask bit is set in the same bus word, so a driver can flip one pin without a read-modify-write. Within a window, the byte offset is `kind * 0x10 + port * 4`, with kind 0 = function select, 1 = drive enable, 2 = drive value and 3 = pad level. Pin `p` of port `q` is bit `8*q + p` of the pad vectors.

Top module: `gpio_bank_regfile`

## Requirements
- R1: After reset every register is zero. `pad_oe` and `pad_out` are all zero, and a read of any register returns zero while the pads are low.
- R2: A plain-window write at offset `kind*0x10 + port*4`, with kind 0, 1 or 2, replaces the register byte with `bus_wdata[7:0]`. A read of that address in the following cycle returns the new byte.
- R3: An alias-window write at `ALIAS_OFS + kind*0x10 + port*4`, with kind 0, 1 or 2, sets register bit n to `bus_wdata[n]` for each n where `bus_wdata[8+n]` is 1. Bits whose mask bit is 0 keep their value. A read through either window returns the register byte.
- R4: Writes to the pad-level register (kind 3) are ignored in both windows. A read of the pad level in the alias window returns zero.
- R5: A read of the plain pad-level register returns `pad_in[8*port+7 : 8*port]` as sampled through a two-flop synchroniser. A pad level held stable from before clock edge k is returned by a read issued for edge k+2.
- R6: `bus_rdata[31:8]` is always zero.
- R7: Addresses outside both windows, offsets at 0x40 or above within a window, and addresses with bits 1:0 not zero are unmapped. Reads of them return zero and writes to them change no register.
- R8: `pad_oe[8q+n]` equals function select AND drive enable of pin n of port q. `pad_out[8q+n]` equals the drive-value bit.
- R9: A read is captured at the clock edge where `bus_en=1` and `bus_we=0`. `bus_rdata` shows the result after that edge and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data (bits 15:8 = mask in the alias window) |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad levels (asynchronous) |
| pad_out | output | 32 | Pad drive values |
| pad_oe | output | 32 | Pad drive enables |

## Verification
A write takes effect at the edge that samples it. Its effect shows on `pad_oe` and `pad_out` just after that edge, and a read issued in the next cycle returns the new byte one edge later. The bench drives on falling edges and samples `bus_rdata` and the pad outputs on the falling edge after the relevant rising edge. For the pad level, the bench holds `pad_in` stable for two rising edges before it issues the read, which matches the synchroniser depth. A reference model updated in the bench decides the expected byte for each access.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PORT_W  = 8;
  localparam int NPORT   = 4;
  localparam int PIN_W   = PORT_W * NPORT;
  localparam int WIN_SZ  = 'h40;

  typedef enum logic [1:0] {
    KIND_FSEL = 2'd0,
    KIND_DEN  = 2'd1,
    KIND_DVAL = 2'd2,
    KIND_LVL  = 2'd3
  } reg_kind_e;

  // New register byte after a write; in the alias window the upper byte is a per-bit mask.
  function automatic logic [PORT_W-1:0] merge_byte(input logic [PORT_W-1:0] cur,
                                                   input logic [2*PORT_W-1:0] wd,
                                                   input logic masked);
    logic [PORT_W-1:0] m;
    m = masked ? wd[2*PORT_W-1:PORT_W] : {PORT_W{1'b1}};
    return (cur & ~m) | (wd[PORT_W-1:0] & m);
  endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BANK_IDX    = 1,
  parameter int BANK_STRIDE = 'h100,
  parameter int ALIAS_OFS   = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NPORT-1:0]  wr_fsel,
  output logic [NPORT-1:0]  wr_den,
  output logic [NPORT-1:0]  wr_dval,
  output logic              wr_masked,
  output logic              rd_hit,
  output reg_kind_e         rd_kind,
  output logic [1:0]        rd_port
);
  localparam logic [ADDR_W-1:0] PLAIN_BASE = ADDR_W'(BANK_IDX * BANK_STRIDE);
  localparam logic [ADDR_W-1:0] ALIAS_BASE = ADDR_W'(BANK_IDX * BANK_STRIDE + ALIAS_OFS);

  logic      in_plain, in_alias, mapped;
  reg_kind_e kind;
  logic [1:0] port;

  // Window bases are multiples of the 64-byte window size.
  assign in_plain = (bus_addr[ADDR_W-1:6] == PLAIN_BASE[ADDR_W-1:6]) && (bus_addr[1:0] == 2'b00);
  assign in_alias = (bus_addr[ADDR_W-1:6] == ALIAS_BASE[ADDR_W-1:6]) && (bus_addr[1:0] == 2'b00);
  assign kind     = reg_kind_e'(bus_addr[5:4]);
  assign port     = bus_addr[3:2];
  assign mapped   = in_plain || (in_alias && kind != KIND_LVL);

  logic wr_go;
  assign wr_go     = bus_en && bus_we && mapped && (kind != KIND_LVL);
  assign wr_masked = in_alias;

  for (genvar q = 0; q < NPORT; q++) begin : g_strb
    assign wr_fsel[q] = wr_go && (kind == KIND_FSEL) && (port == 2'(q));
    assign wr_den[q]  = wr_go && (kind == KIND_DEN)  && (port == 2'(q));
    assign wr_dval[q] = wr_go && (kind == KIND_DVAL) && (port == 2'(q));
  end

  assign rd_hit  = mapped;
  assign rd_kind = kind;
  assign rd_port = port;

  // R7
  unmapped_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_plain && !in_alias) |-> ({wr_fsel, wr_den, wr_dval} == '0));
  // R4
  level_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_fsel, wr_den, wr_dval}));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_fsel,
  input  logic                wr_den,
  input  logic                wr_dval,
  input  logic                wr_masked,
  input  logic [2*PORT_W-1:0] wdata,
  output logic [PORT_W-1:0]   fsel_q,
  output logic [PORT_W-1:0]   den_q,
  output logic [PORT_W-1:0]   dval_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsel_q <= '0;
      den_q  <= '0;
      dval_q <= '0;
    end else begin
      if (wr_fsel) fsel_q <= merge_byte(fsel_q, wdata, wr_masked);
      if (wr_den)  den_q  <= merge_byte(den_q,  wdata, wr_masked);
      if (wr_dval) dval_q <= merge_byte(dval_q, wdata, wr_masked);
    end
  end

  // R2
  plain_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dval && !wr_masked) |=> (dval_q == $past(wdata[PORT_W-1:0])));
  // R3
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fsel && wr_masked) |=> (((fsel_q ^ $past(fsel_q)) & ~$past(wdata[2*PORT_W-1:PORT_W])) == '0));
  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_den && wr_masked) |=> (((den_q ^ $past(wdata[PORT_W-1:0])) & $past(wdata[2*PORT_W-1:PORT_W])) == '0));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;
  logic [1:0]       age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
      age    <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
      if (age != 2'd2) age <= age + 2'd1;
    end
  end

  // R5
  two_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BANK_IDX    = 1,
  parameter int BANK_STRIDE = 'h100,
  parameter int ALIAS_OFS   = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pad_in,
  output logic [31:0]       pad_out,
  output logic [31:0]       pad_oe
);
  logic [NPORT-1:0] wr_fsel, wr_den, wr_dval;
  logic             wr_masked, rd_hit;
  reg_kind_e        rd_kind;
  logic [1:0]       rd_port;
  logic [PIN_W-1:0] lvl_sync;
  logic [PORT_W-1:0] fsel [NPORT];
  logic [PORT_W-1:0] den  [NPORT];
  logic [PORT_W-1:0] dval [NPORT];
  logic [15:0]      unused_wdata;

  assign unused_wdata = bus_wdata[31:16];

  gpio_addr_decode #(
    .ADDR_W(ADDR_W), .BANK_IDX(BANK_IDX), .BANK_STRIDE(BANK_STRIDE), .ALIAS_OFS(ALIAS_OFS)
  ) dec_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .wr_fsel(wr_fsel), .wr_den(wr_den), .wr_dval(wr_dval), .wr_masked(wr_masked),
    .rd_hit(rd_hit), .rd_kind(rd_kind), .rd_port(rd_port)
  );

  for (genvar q = 0; q < NPORT; q++) begin : g_port
    gpio_port_regs regs_i (
      .clk(clk), .rst_n(rst_n),
      .wr_fsel(wr_fsel[q]), .wr_den(wr_den[q]), .wr_dval(wr_dval[q]),
      .wr_masked(wr_masked), .wdata(bus_wdata[15:0]),
      .fsel_q(fsel[q]), .den_q(den[q]), .dval_q(dval[q])
    );
    assign pad_out[q*PORT_W +: PORT_W] = dval[q];
    assign pad_oe[q*PORT_W +: PORT_W]  = fsel[q] & den[q];
  end

  gpio_in_sync #(.WIDTH(PIN_W)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl_sync)
  );

  logic [PORT_W-1:0] rd_byte;
  always_comb begin
    rd_byte = '0;
    if (rd_hit) begin
      unique case (rd_kind)
        KIND_FSEL: rd_byte = fsel[rd_port];
        KIND_DEN:  rd_byte = den[rd_port];
        KIND_DVAL: rd_byte = dval[rd_port];
        KIND_LVL:  rd_byte = lvl_sync[rd_port*PORT_W +: PORT_W];
      endcase
    end
  end

  logic rd_go;
  assign rd_go = bus_en && !bus_we;

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_go) bus_rdata <= {24'd0, rd_byte};
  end

  // R6
  rdata_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:8] == '0);
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> $stable(bus_rdata));
  // R8
  oe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~{fsel[3], fsel[2], fsel[1], fsel[0]}) == '0);
endmodule

// File: tb/gpio_bank_regfile_tb_top.sv
module gpio_bank_regfile_tb_top;
  localparam int ADDR_W = 12;
  localparam int PLAIN  = 'h100;
  localparam int ALIAS  = 'h180;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe;

  always #4 clk = ~clk;

  gpio_bank_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int checks = 0, fails = 0;
  logic [7:0] m_reg [3][4];
  logic done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model of a write: bit by bit, mask honoured only in the alias window.
  function automatic logic [7:0] model_next(logic [7:0] cur, logic [31:0] wd, bit alias_w);
    logic [7:0] r = cur;
    for (int n = 0; n < 8; n++)
      if (!alias_w || wd[8+n]) r[n] = wd[n];
    return r;
  endfunction

  function automatic logic [31:0] exp_oe();
    logic [31:0] v;
    for (int q = 0; q < 4; q++) v[q*8 +: 8] = m_reg[0][q] & m_reg[1][q];
    return v;
  endfunction

  function automatic logic [31:0] exp_out();
    logic [31:0] v;
    for (int q = 0; q < 4; q++) v[q*8 +: 8] = m_reg[2][q];
    return v;
  endfunction

  task automatic bus_write(input int addr, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = ADDR_W'(addr); bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(input int addr, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = ADDR_W'(addr);
    @(negedge clk);
    d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic check_all_regs(input string req);
    logic [31:0] rd;
    for (int k = 0; k < 3; k++)
      for (int q = 0; q < 4; q++) begin
        bus_read(PLAIN + k*'h10 + q*4, rd);
        chk(req, rd, {24'd0, m_reg[k][q]});
      end
  endtask

  initial begin
    logic [31:0] rd, wd, hold;
    int k, q;
    bit aw;
    void'($urandom(32'd1234));
    for (int a = 0; a < 3; a++) for (int b = 0; b < 4; b++) m_reg[a][b] = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);
    check_all_regs("R1");
    bus_read(PLAIN + 'h30, rd); chk("R1 level", rd, 0);

    // R2 directed full-byte write
    bus_write(PLAIN + 'h24, 32'hFFFF_A5C3); m_reg[2][1] = 8'hC3;
    bus_read(PLAIN + 'h24, rd); chk("R2 directed", rd, 32'h0000_00C3);
    chk("R8 pad_out", pad_out, exp_out());
    // R3 masked alias: change only bit 0 and bit 7
    bus_write(ALIAS + 'h24, 32'h0000_8100); m_reg[2][1] = 8'h42;
    bus_read(ALIAS + 'h24, rd); chk("R3 directed", rd, 32'h42);
    // R3 zero mask changes nothing
    bus_write(ALIAS + 'h24, 32'h0000_00FF);
    bus_read(PLAIN + 'h24, rd); chk("R3 zero mask", rd, 32'h42);
    // R4 level register writes ignored; alias level reads zero
    pad_in = 32'h0F0F_0F0F;
    bus_write(PLAIN + 'h30, 32'hFF);
    bus_write(ALIAS + 'h34, 32'hFFFF);
    check_all_regs("R4");
    bus_read(ALIAS + 'h30, rd); chk("R4 alias level read", rd, 0);
    // R7 unmapped writes and reads
    bus_write(PLAIN + 'h40, 32'hFF);
    bus_write(PLAIN + 'h01, 32'hFF);
    bus_write('h000, 32'hFF);
    bus_write(ALIAS + 'h41, 32'hFFFF);
    check_all_regs("R7 writes ignored");
    chk("R7 pad_oe", pad_oe, exp_oe());
    bus_read(PLAIN + 'h02, rd); chk("R7 misaligned read", rd, 0);
    bus_read(PLAIN + 'h44, rd); chk("R7 out of window read", rd, 0);
    // R9 read data holds across a write
    bus_read(PLAIN + 'h24, rd);
    bus_write(PLAIN + 'h00, 32'h11); m_reg[0][0] = 8'h11;
    @(negedge clk);
    chk("R9 hold", bus_rdata, 32'h42);

    // R5 pad level through two-flop synchroniser
    for (int i = 0; i < 20; i++) begin
      pad_in = $urandom;
      @(negedge clk); @(negedge clk);
      q = i % 4;
      bus_read(PLAIN + 'h30 + q*4, rd);
      chk("R5 level", rd, {24'd0, pad_in[q*8 +: 8]});
    end

    // Random mix: R2, R3, R6, R7, R8
    for (int i = 0; i < 400; i++) begin
      k = $urandom_range(0, 3);
      q = $urandom_range(0, 3);
      aw = $urandom_range(0, 1);
      wd = $urandom;
      if ($urandom_range(0, 9) == 0) begin
        bus_write((aw ? ALIAS : PLAIN) + 'h40 + $urandom_range(0, 15)*4, wd); // R7
      end else begin
        bus_write((aw ? ALIAS : PLAIN) + k*'h10 + q*4, wd);
        if (k != 3) m_reg[k][q] = model_next(m_reg[k][q], wd, aw);
      end
      chk("R8 pad_oe", pad_oe, exp_oe());
      chk("R8 pad_out", pad_out, exp_out());
      if (k != 3) begin
        bus_read((aw ? ALIAS : PLAIN) + k*'h10 + q*4, rd);
        chk(aw ? "R3 random" : "R2 random", rd, {24'd0, m_reg[k][q]});
        chk("R6 upper zero", {8'd0, rd[31:8]}, 0);
      end
    end
    check_all_regs("R2 final");
    hold = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule